// File: doc/BRIEF.md
# Signed Widening Vector Shift Unit

This block takes a 128-bit packed source vector and selects one 64-bit half of it. It splits that half into signed lanes, doubles the width of each lane with sign extension, and shifts each widened lane left by a constant amount. The widened lanes are packed into a 128-bit result. The lane width and the shift amount both come from one 7-bit immediate, which arrives as a 4-bit high field and a 3-bit low field. The highest set bit among the three low bits of the high field picks the lane width. The shift amount is the whole immediate minus that lane width.

Each request is marked by an input valid strobe. The result appears one clock later, together with an output valid strobe and two encoding flags. One flag marks an encoding that belongs to another instruction class. The other flag marks an undefined encoding. For either flag the result bus is forced to zero.

Between requests the output registers keep their last value. The reset is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `swl_shift_unit`

## Requirements
- R1: When `in_upper` is 0 the lanes come from `in_src[63:0]`. When it is 1 they come from `in_src[127:64]`. Source lane e sits at bits [e*W +: W] of the selected half, where W is the lane width.
- R2: The lane width W comes from `in_immh[2:0]`. Pattern 001 gives W=8, 01x gives W=16 and 1xx gives W=32. The block processes 64/W lanes, which is 8, 4 or 2 lanes. Result lane e occupies `out_result[e*2W +: 2W]`.
- R3: The shift amount is the unsigned value of `{in_immh, in_immb}` minus W. This gives a range of 0 to W-1.
- R4: Each source lane is sign-extended to 2W bits and then shifted left. Only the low 2W bits of the shifted value are kept. This holds for the most negative value, the most positive value and zero.
- R5: When `in_immh` is 0000, the outputs are `out_other_class`=1, `out_undef`=0 and `out_result` all zeros.
- R6: When `in_immh[3]` is 1, the outputs are `out_undef`=1, `out_other_class`=0 and `out_result` all zeros.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The result and flags in that cycle belong to the input that was accepted.
- R8: While reset is asserted, `out_valid`, `out_undef` and `out_other_class` are 0 and `out_result` is all zeros.
- R9: In a cycle with `in_valid` low, `out_result`, `out_undef` and `out_other_class` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_src | input | 128 | Packed source vector |
| in_upper | input | 1 | Half select: 0 = low 64 bits, 1 = high 64 bits |
| in_immh | input | 4 | High immediate field |
| in_immb | input | 3 | Low immediate field |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 128 | Packed double-width shifted lanes |
| out_undef | output | 1 | Undefined encoding flag |
| out_other_class | output | 1 | Encoding belongs to another instruction class |

## Verification
A wrong width decode shows up at the ports in the first result cycle. The lane boundaries move and a whole group of result lanes goes wrong. A shift amount that is off by one scales every nonzero lane by a factor of two. A lost sign extension breaks the negative lanes only, most clearly the most negative value. All of these are visible on the same clock as `out_valid`. A clock-enable fault in the output registers shows as a result that changes during an idle cycle, which is visible one cycle after the request ends.

// File: rtl/swl_pkg.sv
package swl_pkg;

  localparam int IMMH_W     = 4;
  localparam int IMMB_W     = 3;
  localparam int IMM_W      = IMMH_W + IMMB_W;
  localparam int HALF_W     = 64;
  localparam int SRC_W      = 2 * HALF_W;
  localparam int LANE_MIN_W = 8;
  localparam int NUM_WIDTHS = IMMH_W - 1;
  localparam int LANE_MAX_W = LANE_MIN_W << (NUM_WIDTHS - 1);
  localparam int SHAMT_W    = $clog2(LANE_MAX_W);
  localparam int IDX_W      = $clog2(NUM_WIDTHS);

  typedef struct packed {
    logic [NUM_WIDTHS-1:0] width_oh;
    logic [SHAMT_W-1:0]    shamt;
    logic                  undef;
    logic                  other;
  } swl_dec_t;

endpackage

// File: rtl/swl_rst_sync.sv
module swl_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/swl_decode.sv
module swl_decode
  import swl_pkg::*;
(
  input  logic [IMMH_W-1:0] immh,
  input  logic [IMMB_W-1:0] immb,
  output swl_dec_t          dec
);

  logic [IMM_W-1:0] imm_val;
  logic [IMM_W-1:0] esize;
  logic [IMM_W-1:0] diff;
  logic [IDX_W-1:0] top_idx;
  logic             is_other;
  logic             is_undef;

  assign imm_val  = {immh, immb};
  assign is_other = (immh == '0);
  assign is_undef = immh[IMMH_W-1];

  // Highest set bit of the lower bits of the high field selects the width.
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < NUM_WIDTHS; i++) begin
      if (immh[i]) top_idx = IDX_W'(i);
    end
  end

  assign esize = IMM_W'(LANE_MIN_W) << top_idx;
  assign diff  = imm_val - esize;

  always_comb begin
    dec          = '0;
    dec.other    = is_other;
    dec.undef    = is_undef;
    dec.shamt    = diff[SHAMT_W-1:0];
    if (!is_other && !is_undef) begin
      dec.width_oh = NUM_WIDTHS'(1) << top_idx;
    end
  end

endmodule

// File: rtl/swl_lane_bank.sv
module swl_lane_bank #(
  parameter int LANE_W  = 8,
  parameter int HALF_W  = 64,
  parameter int SHAMT_W = 5
) (
  input  logic [HALF_W-1:0]   operand,
  input  logic [SHAMT_W-1:0]  shamt,
  output logic [2*HALF_W-1:0] result
);

  localparam int LANES  = HALF_W / LANE_W;
  localparam int WIDE_W = 2 * LANE_W;

  for (genvar li = 0; li < LANES; li++) begin : g_lane
    logic [LANE_W-1:0] narrow;
    logic [WIDE_W-1:0] wide;
    assign narrow = operand[li*LANE_W +: LANE_W];
    assign wide   = {{LANE_W{narrow[LANE_W-1]}}, narrow};
    assign result[li*WIDE_W +: WIDE_W] = wide << shamt;
  end

endmodule

// File: rtl/swl_shift_unit.sv
module swl_shift_unit
  import swl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SRC_W-1:0]  in_src,
  input  logic              in_upper,
  input  logic [IMMH_W-1:0] in_immh,
  input  logic [IMMB_W-1:0] in_immb,
  output logic              out_valid,
  output logic [SRC_W-1:0]  out_result,
  output logic              out_undef,
  output logic              out_other_class
);

  logic rst_n_sync;

  swl_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  swl_dec_t dec;

  swl_decode u_decode (
    .immh (in_immh),
    .immb (in_immb),
    .dec  (dec)
  );

  logic [HALF_W-1:0] operand;
  assign operand = in_upper ? in_src[SRC_W-1:HALF_W] : in_src[HALF_W-1:0];

  logic [SRC_W-1:0] bank_res [NUM_WIDTHS];

  for (genvar gi = 0; gi < NUM_WIDTHS; gi++) begin : g_bank
    swl_lane_bank #(
      .LANE_W  (LANE_MIN_W << gi),
      .HALF_W  (HALF_W),
      .SHAMT_W (SHAMT_W)
    ) u_bank (
      .operand (operand),
      .shamt   (dec.shamt),
      .result  (bank_res[gi])
    );
  end

  // One-hot AND-OR select; an illegal encoding has an empty one-hot.
  logic [SRC_W-1:0] sel_res;
  always_comb begin
    sel_res = '0;
    for (int i = 0; i < NUM_WIDTHS; i++) begin
      sel_res = sel_res | (bank_res[i] & {SRC_W{dec.width_oh[i]}});
    end
  end

  // Next-state
  logic             valid_d;
  logic [SRC_W-1:0] result_d;
  logic             undef_d;
  logic             other_d;
  logic             cap_en;

  assign cap_en = in_valid;

  always_comb begin
    valid_d  = in_valid;
    result_d = out_result;
    undef_d  = out_undef;
    other_d  = out_other_class;
    if (cap_en) begin
      result_d = sel_res;
      undef_d  = dec.undef;
      other_d  = dec.other;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      out_valid       <= 1'b0;
      out_result      <= '0;
      out_undef       <= 1'b0;
      out_other_class <= 1'b0;
    end else begin
      out_valid       <= valid_d;
      out_result      <= result_d;
      out_undef       <= undef_d;
      out_other_class <= other_d;
    end
  end

  AST_WIDTH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    in_valid |-> $onehot0(dec.width_oh)); // R2
  AST_LEGAL_HAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && !dec.undef && !dec.other) |-> $onehot(dec.width_oh)); // R2
  AST_SHIFT_RANGE8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && dec.width_oh[0]) |-> (dec.shamt < SHAMT_W'(LANE_MIN_W))); // R3
  AST_SHIFT_RANGE16: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && dec.width_oh[1]) |-> (dec.shamt < SHAMT_W'(2*LANE_MIN_W))); // R3
  AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n_sync)
    out_other_class |-> (out_result == '0)); // R5
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n_sync)
    out_undef |-> (out_result == '0)); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(out_undef && out_other_class)); // R6
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    in_valid |=> out_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_valid |=> !out_valid); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_valid |=> ($stable(out_result) && $stable(out_undef) && $stable(out_other_class))); // R9

endmodule

// File: tb/tb_swl_shift_unit.sv
`timescale 1ns/1ps
module tb_swl_shift_unit;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_src;
  logic         in_upper;
  logic [3:0]   in_immh;
  logic [2:0]   in_immb;
  logic         out_valid;
  logic [127:0] out_result;
  logic         out_undef;
  logic         out_other_class;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  swl_shift_unit dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_src          (in_src),
    .in_upper        (in_upper),
    .in_immh         (in_immh),
    .in_immb         (in_immb),
    .out_valid       (out_valid),
    .out_result      (out_result),
    .out_undef       (out_undef),
    .out_other_class (out_other_class)
  );

  function automatic logic [127:0] model(input logic [127:0] src, input logic up,
                                         input logic [3:0] h, input logic [2:0] b,
                                         output logic undef, output logic oth);
    int w, sh;
    logic [63:0] op, u, m2;
    longint el;
    logic [127:0] r;
    r = '0;
    oth   = (h == 4'd0);
    undef = h[3];
    if (oth || undef) return r;
    w  = h[2] ? 32 : (h[1] ? 16 : 8);
    sh = int'({h, b}) - w;
    op = up ? src[127:64] : src[63:0];
    m2 = (2*w == 64) ? '1 : ((64'd1 << (2*w)) - 64'd1);
    for (int e = 0; e < 64/w; e++) begin
      el = longint'((op >> (e*w)) & ((64'd1 << w) - 64'd1));
      if (el[w-1]) el = el - (longint'(1) << w);
      el = el << sh;
      u  = el;
      r  = r | ({64'd0, u & m2} << (e*2*w));
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request at a falling edge, check at the next falling edge.
  task automatic run(input logic [127:0] src, input logic up, input logic [3:0] h,
                     input logic [2:0] b, input string tag, input bit idle_after);
    logic [127:0] exp_r;
    logic eu, eo;
    exp_r = model(src, up, h, b, eu, eo);
    @(negedge clk);
    in_valid = 1'b1; in_src = src; in_upper = up; in_immh = h; in_immb = b;
    @(negedge clk);
    check(out_valid === 1'b1 && out_result === exp_r && out_undef === eu &&
          out_other_class === eo, tag, {out_valid, out_undef, out_other_class, out_result[124:0]},
          {1'b1, eu, eo, exp_r[124:0]});
    check(out_result === exp_r, tag, out_result, exp_r);
    if (idle_after) begin
      in_valid = 1'b0;
      in_src = ~src; in_immh = 4'd1; in_immb = 3'd5; in_upper = ~up;
      @(negedge clk);
      // R7 strobe drops, R9 outputs held
      check(out_valid === 1'b0, "R7 idle strobe", {127'd0, out_valid}, 128'd0);
      check(out_result === exp_r && out_undef === eu && out_other_class === eo,
            "R9 hold", out_result, exp_r);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] pat_a, pat_b, src;
    int seed_init;
    seed_init = $urandom(32'h5a17);
    rst_n = 1'b0; in_valid = 1'b0; in_src = '0; in_upper = 1'b0;
    in_immh = 4'd0; in_immb = 3'd0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(out_valid === 1'b0 && out_undef === 1'b0 && out_other_class === 1'b0 &&
          out_result === '0, "R8 reset", out_result, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Min, max, zero and -1 in every lane width.
    pat_a = {64'h8000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF};
    pat_b = {64'h7F80_00FF_8000_7FFF, 64'h1234_5678_9ABC_DEF0};

    // R1 R2 R3 R4 full sweep of legal immediates and both halves
    for (int h = 1; h < 8; h++) begin
      for (int b = 0; b < 8; b++) begin
        for (int up = 0; up < 2; up++) begin
          run(pat_a, up[0], h[3:0], b[2:0], "R4 sweep A", 1'b0);
          run(pat_b, up[0], h[3:0], b[2:0], "R1 sweep B", (b == 7));
        end
      end
    end

    // R3 boundary shifts: zero and maximum for each width
    run(pat_a, 1'b1, 4'b0001, 3'd0, "R3 w8 shift0", 1'b0);
    run(pat_a, 1'b1, 4'b0001, 3'd7, "R3 w8 shift7", 1'b0);
    run(pat_a, 1'b0, 4'b0011, 3'd7, "R3 w16 shift15", 1'b0);
    run(pat_a, 1'b1, 4'b0111, 3'd7, "R3 w32 shift31", 1'b1);

    // R5 other-class encoding
    run(pat_b, 1'b0, 4'b0000, 3'd3, "R5 other class", 1'b1);
    // R6 undefined encodings
    run(pat_b, 1'b1, 4'b1000, 3'd0, "R6 undef", 1'b0);
    run(pat_a, 1'b0, 4'b1111, 3'd7, "R6 undef all ones", 1'b1);

    // R2 R7 random mix, back-to-back
    for (int i = 0; i < 400; i++) begin
      src = {$urandom, $urandom, $urandom, $urandom};
      run(src, 1'($urandom), 4'($urandom), 3'($urandom), "R2 random", ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule